// File: doc/BRIEF.md
# Single-to-Double Precision Widening Converter

This block widens a 32-bit IEEE-754 single-precision word into the 64-bit double-precision register image that a floating-point load path writes into its register file. One word is accepted on every cycle in which the input strobe is high. The widened result shows up one clock later, together with an output strobe. The conversion is exact: every single-precision value, including subnormals, has an exact double-precision image, so the block does no rounding and raises no flags.

Normal numbers, zeros, infinities and NaNs pass through a fixed bit-mapping. The exponent is widened by replicating its top bit rather than by re-biasing it with an adder. Subnormal singles are renormalized into normal doubles with a leading-zero count over the 23-bit fraction. A parameter picks one of two leading-zero counter structures, and both produce the same result bit for bit.

Bit numbering in this brief is MSB-first: bit 0 is the sign. In the ports, input bit k is `in_word[31-k]` and output bit k is `out_word[63-k]`.

Top module: `fp_widen_s2d`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_vld` and `out_word` are cleared to zero on that edge, whatever `in_vld` and `in_word` carry.
- R2: `out_vld` is high on the cycle after each cycle in which `in_vld` was high, and low on the cycle after each cycle in which it was low.
- R3: When `in_vld` is low, `out_word` keeps its previous value, whatever `in_word` carries.
- R4: Output bit 0 (the sign, `out_word[63]`) always equals input bit 0 (`in_word[31]`) of the accepted word.
- R5: For an input exponent field (bits 1..8) strictly between 0 and 255, output bits 0..1 equal input bits 0..1, output bits 2..4 are each the inverse of input bit 1, and output bits 5..63 are input bits 2..31 followed by 29 zeros. For example, 0x3F800000 gives 0x3FF0000000000000.
- R6: An input whose bits 1..31 are all zero (a signed zero) gives an output that is zero everywhere except the sign bit.
- R7: An input with exponent field 255 gives an output exponent (bits 1..11) of all ones, and an output fraction equal to the 23 input fraction bits followed by 29 zeros. NaN payloads, including the quiet bit, are passed through unchanged.
- R8: For a subnormal input (exponent field 0, fraction nonzero), the output exponent field is 896 minus the number of leading zeros in the 23-bit input fraction. The values therefore range from 874 to 896.
- R9: For a subnormal input, the output fraction is the input fraction bits that follow its leading 1, left-aligned, with zeros filling the rest of the 52 bits.
- R10: Both leading-zero counter styles (`NORM_STYLE` 0 and 1) produce the same output for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | Single-precision word, sign in the MSB |
| out_vld | output | 1 | Result is valid this cycle |
| out_word | output | 64 | Double-precision image, sign in the MSB |

## Verification
The bench sweeps every subnormal whose fraction has exactly one bit set, for both signs. An off-by-one in the leading-zero count or in the exponent base would show up there as an exponent wrong by one, and a shift applied without the extra position would leave the hidden 1 inside the fraction. Signed zeros are checked because treating them as normals would produce an exponent of 0x380 instead of zero. Infinities and both quiet and signalling NaNs are checked because inverting the replicated bit on them would turn them into finite numbers with exponent 0x47F. Words that differ in bit 1 catch a replication that copies the wrong bit.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
   typedef enum logic [1:0] {
      CLS_NORMAL  = 2'd0,
      CLS_DENORM  = 2'd1,
      CLS_SPECIAL = 2'd2
   } cls_e;
endpackage

// File: rtl/fpw_classify.sv
module fpw_classify #(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23
) (
   input  logic [SP_EXP_W+SP_FRAC_W:0] word,
   output fpw_pkg::cls_e               cls
);
   logic [SP_EXP_W-1:0]  exp_f;
   logic [SP_FRAC_W-1:0] frac_f;

   assign exp_f  = word[SP_EXP_W+SP_FRAC_W-1 -: SP_EXP_W];
   assign frac_f = word[SP_FRAC_W-1:0];

   always_comb begin
      if ((&exp_f) || (word[SP_EXP_W+SP_FRAC_W-1:0] == '0))
         cls = fpw_pkg::CLS_SPECIAL;
      else if (exp_f == '0)
         cls = fpw_pkg::CLS_DENORM;
      else
         cls = fpw_pkg::CLS_NORMAL;
   end
endmodule

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
   parameter int W     = 23,
   parameter int STYLE = 0,
   parameter int CW    = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);
   generate
      if (STYLE == 0) begin : g_scan
         // linear priority scan: the highest set bit is written last and wins
         always_comb begin
            cnt = CW'(W);
            for (int i = 0; i < W; i++)
               if (vec[i]) cnt = CW'(W - 1 - i);
         end
      end else begin : g_tree
         localparam int LG = (W > 1) ? $clog2(W) : 1;
         localparam int P  = 1 << LG;
         logic [P-1:0]  padded;
         logic [P-1:0]  cur;
         logic [LG-1:0] acc;
         if (P > W) begin : g_pad
            assign padded = {vec, {(P-W){1'b0}}};
         end else begin : g_nopad
            assign padded = vec;
         end
         // binary search: halve the window each stage, shift away zero halves
         always_comb begin
            cur = padded;
            acc = '0;
            for (int s = LG - 1; s >= 0; s--) begin
               if ((cur >> (P - (1 << s))) == '0) begin
                  acc[s] = 1'b1;
                  cur    = cur << (1 << s);
               end
            end
            cnt = CW'(acc);
         end
      end
   endgenerate
endmodule

// File: rtl/fpw_denorm.sv
module fpw_denorm #(
   parameter int SP_EXP_W   = 8,
   parameter int SP_FRAC_W  = 23,
   parameter int DP_EXP_W   = 11,
   parameter int DP_FRAC_W  = 52,
   parameter int NORM_STYLE = 0
) (
   input  logic [SP_FRAC_W-1:0] frac_i,
   output logic [DP_EXP_W-1:0]  exp_o,
   output logic [DP_FRAC_W-1:0] frac_o
);
   localparam int CW      = $clog2(SP_FRAC_W + 1);
   localparam int SP_BIAS = (1 << (SP_EXP_W - 1)) - 1;
   localparam int DP_BIAS = (1 << (DP_EXP_W - 1)) - 1;
   localparam int BASE    = DP_BIAS - SP_BIAS;
   localparam int PAD     = DP_FRAC_W - SP_FRAC_W;

   logic [CW-1:0]        lz;
   logic [SP_FRAC_W-1:0] aligned;

   fpw_lzc #(.W(SP_FRAC_W), .STYLE(NORM_STYLE), .CW(CW)) u_lzc (
      .vec (frac_i),
      .cnt (lz)
   );

   // after this shift the leading 1 sits in the MSB; it becomes the hidden bit
   assign aligned = frac_i << lz;
   assign frac_o  = {aligned[SP_FRAC_W-2:0], {(PAD+1){1'b0}}};
   assign exp_o   = DP_EXP_W'(BASE) - DP_EXP_W'(lz);
endmodule

// File: rtl/fp_widen_s2d.sv
module fp_widen_s2d #(
   parameter int SP_EXP_W   = 8,
   parameter int SP_FRAC_W  = 23,
   parameter int DP_EXP_W   = 11,
   parameter int DP_FRAC_W  = 52,
   parameter int NORM_STYLE = 0
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_vld,
   input  logic [SP_EXP_W+SP_FRAC_W:0]  in_word,
   output logic                         out_vld,
   output logic [DP_EXP_W+DP_FRAC_W:0]  out_word
);
   localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W;
   localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W;
   localparam int FILL = DP_EXP_W - SP_EXP_W;
   localparam int PAD  = DP_FRAC_W - SP_FRAC_W;

   generate
      if (FILL < 1 || PAD < 0) begin : g_bad_fmt
         $error("fp_widen_s2d: destination format must be wider than source");
      end
      if (NORM_STYLE < 0 || NORM_STYLE > 1) begin : g_bad_style
         $error("fp_widen_s2d: NORM_STYLE must be 0 or 1");
      end
      if (SP_EXP_W < 2 || SP_FRAC_W < 2) begin : g_bad_src
         $error("fp_widen_s2d: source fields too narrow");
      end
   endgenerate

   fpw_pkg::cls_e        cls;
   logic                 fill_bit;
   logic [DP_W-1:0]      direct_img;
   logic [DP_W-1:0]      denorm_img;
   logic [DP_W-1:0]      next_img;
   logic [DP_EXP_W-1:0]  dn_exp;
   logic [DP_FRAC_W-1:0] dn_frac;

   fpw_classify #(.SP_EXP_W(SP_EXP_W), .SP_FRAC_W(SP_FRAC_W)) u_cls (
      .word (in_word),
      .cls  (cls)
   );

   fpw_denorm #(
      .SP_EXP_W   (SP_EXP_W),
      .SP_FRAC_W  (SP_FRAC_W),
      .DP_EXP_W   (DP_EXP_W),
      .DP_FRAC_W  (DP_FRAC_W),
      .NORM_STYLE (NORM_STYLE)
   ) u_dn (
      .frac_i (in_word[SP_FRAC_W-1:0]),
      .exp_o  (dn_exp),
      .frac_o (dn_frac)
   );

   // exponent widening by replication: specials copy the top bit, normals invert it
   assign fill_bit   = (cls == fpw_pkg::CLS_SPECIAL) ? in_word[SP_W-2] : ~in_word[SP_W-2];
   assign direct_img = {in_word[SP_W-1], in_word[SP_W-2], {FILL{fill_bit}},
                        in_word[SP_W-3:0], {PAD{1'b0}}};
   assign denorm_img = {in_word[SP_W-1], dn_exp, dn_frac};
   assign next_img   = (cls == fpw_pkg::CLS_DENORM) ? denorm_img : direct_img;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         out_word <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_word <= next_img;
      end
   end
endmodule

// File: rtl/fpw_check.sv
module fpw_check #(
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        in_vld,
   input logic [SP_EXP_W+SP_FRAC_W:0] in_word,
   input logic                        out_vld,
   input logic [DP_EXP_W+DP_FRAC_W:0] out_word
);
   localparam int SP_W  = 1 + SP_EXP_W + SP_FRAC_W;
   localparam int DP_W  = 1 + DP_EXP_W + DP_FRAC_W;
   localparam int DMAX  = ((1 << (DP_EXP_W - 1)) - 1) - ((1 << (SP_EXP_W - 1)) - 1);
   localparam int DMIN  = DMAX - (SP_FRAC_W - 1);

   logic is_inf_nan, is_zero, is_sub;
   assign is_inf_nan = &in_word[SP_W-2 -: SP_EXP_W];
   assign is_zero    = (in_word[SP_W-2:0] == '0);
   assign is_sub     = (in_word[SP_W-2 -: SP_EXP_W] == '0) && !is_zero;

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!out_vld && out_word == '0));

   p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);

   p_vld_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);

   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(out_word));

   p_sign_r4: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_word[DP_W-1] == $past(in_word[SP_W-1]));

   p_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (in_vld && is_zero) |=> out_word[DP_W-2:0] == '0);

   p_special_exp_r7: assert property (@(posedge clk) disable iff (rst)
      (in_vld && is_inf_nan) |=> (&out_word[DP_W-2 -: DP_EXP_W]));

   p_sub_range_r8: assert property (@(posedge clk) disable iff (rst)
      (in_vld && is_sub) |=>
         (int'(out_word[DP_W-2 -: DP_EXP_W]) >= DMIN &&
          int'(out_word[DP_W-2 -: DP_EXP_W]) <= DMAX));
endmodule

bind fp_widen_s2d fpw_check #(
   .SP_EXP_W  (SP_EXP_W),
   .SP_FRAC_W (SP_FRAC_W),
   .DP_EXP_W  (DP_EXP_W),
   .DP_FRAC_W (DP_FRAC_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_vld   (in_vld),
   .in_word  (in_word),
   .out_vld  (out_vld),
   .out_word (out_word)
);

// File: tb/sim_fp_widen_s2d.sv
module sim_fp_widen_s2d;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_vld;
   logic [31:0] in_word;
   logic        vld0, vld1;
   logic [63:0] out0, out1;
   int          n_run  = 0;
   int          n_fail = 0;
   bit          done   = 1'b0;

   always #4 clk = ~clk;

   fp_widen_s2d #(.NORM_STYLE(0)) u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word),
      .out_vld(vld0), .out_word(out0));

   fp_widen_s2d #(.NORM_STYLE(1)) u1 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word),
      .out_vld(vld1), .out_word(out1));

   // reference built from the stated algorithm: shift loop for subnormals
   function automatic logic [63:0] ref_w(input logic [31:0] w);
      int          ex;
      logic [52:0] fr;
      if (w[30:23] == 8'hFF || w[30:0] == 31'd0)
         return {w[31], w[30], {3{w[30]}}, w[29:0], 29'd0};
      if (w[30:23] != 8'd0)
         return {w[31], w[30], {3{~w[30]}}, w[29:0], 29'd0};
      ex = -126;
      fr = {1'b0, w[22:0], 29'd0};
      while (!fr[52]) begin
         fr = {fr[51:0], 1'b0};
         ex = ex - 1;
      end
      return {w[31], 11'(ex + 1023), fr[51:0]};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one word for one cycle, then sample both outputs at the following negedge
   task automatic apply(input logic [31:0] w, input string req);
      @(negedge clk);
      in_vld  = 1'b1;
      in_word = w;
      @(negedge clk);
      in_vld  = 1'b0;
      chk({req, " vld R2"}, {63'd0, vld0}, 64'd1);
      chk(req, out0, ref_w(w));
      chk({req, " style match R10"}, out1, out0);
   endtask

   task automatic t_reset();
      rst = 1'b1; in_vld = 1'b1; in_word = 32'h3F80_0000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 out_vld in reset", {63'd0, vld0}, 64'd0);
      chk("R1 out_word in reset", out0, 64'd0);
      rst = 1'b0; in_vld = 1'b0;
      @(negedge clk);
      chk("R2 idle after reset", {63'd0, vld0}, 64'd0);
   endtask

   task automatic t_normals();
      apply(32'h3F80_0000, "R5 one");
      chk("R5 one literal", out0, 64'h3FF0_0000_0000_0000);
      apply(32'hC000_0000, "R5 minus two");
      chk("R5 minus two literal", out0, 64'hC000_0000_0000_0000);
      chk("R4 sign set", {63'd0, out0[63]}, 64'd1);
      apply(32'h0080_0000, "R5 min normal");
      apply(32'h7F7F_FFFF, "R5 max normal");
      apply(32'h4049_0FDB, "R5 pi");
      apply(32'hBEAA_AAAB, "R5 neg third");
   endtask

   task automatic t_zeros();
      apply(32'h0000_0000, "R6 plus zero");
      chk("R6 plus zero literal", out0, 64'h0);
      apply(32'h8000_0000, "R6 minus zero");
      chk("R6 minus zero literal", out0, 64'h8000_0000_0000_0000);
   endtask

   task automatic t_specials();
      apply(32'h7F80_0000, "R7 plus inf");
      chk("R7 plus inf literal", out0, 64'h7FF0_0000_0000_0000);
      apply(32'hFF80_0000, "R7 minus inf");
      chk("R7 minus inf literal", out0, 64'hFFF0_0000_0000_0000);
      apply(32'h7FC0_0000, "R7 quiet nan");
      chk("R7 quiet nan literal", out0, 64'h7FF8_0000_0000_0000);
      apply(32'h7F80_0001, "R7 signalling nan");
      chk("R7 signalling nan literal", out0, 64'h7FF0_0000_2000_0000);
      apply(32'hFFA5_5A5A, "R7 neg nan payload");
   endtask

   task automatic t_subnormal_bits();
      for (int b = 0; b < 23; b++) begin
         apply({9'd0, 23'(1) << b}, "R8 R9 single bit pos");
         apply({1'b1, 8'd0, 23'(1) << b}, "R8 R9 single bit neg");
         chk("R4 sign of subnormal", {63'd0, out0[63]}, 64'd1);
      end
      apply(32'h0000_0001, "R8 smallest");
      chk("R8 smallest literal", out0, 64'h36A0_0000_0000_0000);
      apply(32'h0040_0000, "R8 top bit");
      chk("R8 top bit literal", out0, 64'h3800_0000_0000_0000);
   endtask

   task automatic t_subnormal_mixed();
      apply(32'h007F_FFFF, "R9 all ones fraction");
      apply(32'h0000_0003, "R9 two low bits");
      apply(32'h8012_3456, "R9 mixed pattern");
      apply(32'h0000_1001, "R9 sparse pattern");
   endtask

   task automatic t_hold();
      logic [63:0] keep;
      apply(32'h4120_0000, "R3 setup");
      keep = out0;
      @(negedge clk);
      in_word = 32'h7FC0_0000;
      @(negedge clk);
      chk("R3 held while idle", out0, keep);
      chk("R2 low while idle", {63'd0, vld0}, 64'd0);
      in_word = 32'h0000_0005;
      @(negedge clk);
      chk("R3 held second cycle", out0, keep);
   endtask

   initial begin
      t_reset();
      t_normals();
      t_zeros();
      t_specials();
      t_subnormal_bits();
      t_subnormal_mixed();
      t_hold();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule